// File: doc/BRIEF.md
# Unaligned Byte-to-Word Program Packer

This block sits between a byte producer and a flash controller that can only program whole 32-bit aligned words. A transfer starts with a byte address, a byte count and a start pulse. The bytes then arrive one per handshake on a valid/ready input. The packer splits the transfer into a run of aligned word-program requests.

Before it builds each word, the packer reads that word from the flash array. Byte lanes that the transfer does not cover keep the value already stored there. This covers the lanes below the start offset in the first word and the lanes above the last byte in the final word. Each assembled word is programmed only if it needs nothing but one-to-zero bit changes against the stored value.

The transfer ends at the first failure: a word that is not erased enough, or an error status from the controller. It also ends after the last word is programmed. The packer then raises a one-cycle done pulse together with a two-bit status code.

Top module: `bwp_packer`

## Requirements
- R1: The first word address issued is the start address with its two low bits forced to zero. Every later word address is 4 above the previous one. Every read and program address has its two low bits at zero.
- R2: Words are little-endian: the byte at address a lands in lane a mod 4, bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at address a with the low two bits cleared.
- R3: In the first word, the lanes below the start offset carry the bytes read from flash at that word.
- R4: In the last word, the lanes above the final transfer byte carry the bytes read from flash at that word.
- R5: A word is sent for programming only if (stored AND new) equals new. Otherwise the packer issues no program request for that word, ends the transfer and reports status 1 (not erased).
- R6: A program acknowledge with a nonzero status (2 = timeout, 3 = protection error) ends the transfer at once and reports that same code. No further reads, program requests or byte acceptances follow.
- R7: A start with a byte count of zero completes with status 0 (success). It issues no read and no program request.
- R8: The read of a word completes before that word's program request. Read and program requests are never raised together. A program request, with its address and data, stays stable until it is acknowledged.
- R9: Each transfer ends with exactly one done pulse of one cycle, with status 0 on success. The status output holds the last code and is 0 after reset. Done is never high while busy.
- R10: byte_ready is high only while a word is being filled and is low while idle. A start pulse that arrives while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | ADDR_W | Byte address of the first byte |
| byte_count | input | CNT_W | Number of bytes in the transfer |
| byte_valid | input | 1 | Input byte is present |
| byte_data | input | 8 | Input byte |
| byte_ready | output | 1 | Packer takes the byte this cycle if valid |
| rd_req | output | 1 | Request to read the flash word at rd_addr |
| rd_addr | output | ADDR_W | Aligned byte address of the word to read |
| rd_valid | input | 1 | Read data is present on rd_data |
| rd_data | input | 32 | Stored flash word |
| prog_req | output | 1 | Word-program request, held until acknowledged |
| prog_addr | output | ADDR_W | Aligned byte address of the word to program |
| prog_data | output | 32 | Word to program |
| prog_ack | input | 1 | Controller has finished the program request |
| prog_status | input | 2 | Result code that comes with prog_ack (0 ok, 2 timeout, 3 protection) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| status | output | 2 | Last result: 0 ok, 1 not erased, 2 timeout, 3 protection |

## Verification
The bench builds the packer with ADDR_W = 6 and CNT_W = 6, which gives a 64-byte, 16-word flash model small enough to compare in full after every transfer. With this size the bench sweeps every start offset from 0 to 3 against every count from 0 to 13 at two base addresses. This covers single-word transfers that touch both head and tail, the zero-count case, transfers that end exactly on a word boundary and multi-word runs. Failure runs place a zero byte under the first or a later word, or inject a timeout or protection code on a chosen program request, so that the stopping point can be counted in words and bytes.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    // Geometry of one program word
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    // Result codes reported with done
    typedef enum logic [1:0] {
        ST_OK         = 2'd0,
        ST_NOT_ERASED = 2'd1,
        ST_TIMEOUT    = 2'd2,
        ST_PROTECT    = 2'd3
    } pk_status_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_FILL  = 3'd2,
        PH_CHECK = 3'd3,
        PH_PROG  = 3'd4
    } pk_phase_e;

endpackage

// File: rtl/bwp_lane_merge.sv
// Replaces one byte lane of a word, leaving the other lanes untouched.
module bwp_lane_merge
    import bwp_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES*BYTE_W-1:0]   word_in,
    input  logic [$clog2(N_LANES)-1:0]  lane_sel,
    input  logic [BYTE_W-1:0]           byte_in,
    output logic [N_LANES*BYTE_W-1:0]   word_out
);

    localparam int SEL_W = $clog2(N_LANES);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign word_out[g*BYTE_W +: BYTE_W] =
            (lane_sel == SEL_W'(g)) ? byte_in : word_in[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/bwp_erase_check.sv
// A new word is programmable when it only clears bits of the stored word.
module bwp_erase_check #(
    parameter int W = 32
) (
    input  logic [W-1:0] stored,
    input  logic [W-1:0] wanted,
    output logic         ok
);

    logic [W-1:0] needs_set;

    // Bits that would have to go from 0 to 1
    assign needs_set = wanted & ~stored;
    assign ok        = (needs_set == '0);

endmodule

// File: rtl/bwp_packer.sv
module bwp_packer
    import bwp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [31:0]       prog_data,
    input  logic              prog_ack,
    input  logic [1:0]        prog_status,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);
    localparam logic [CNT_W-1:0]  ONE_LEFT  = CNT_W'(1);

    typedef struct packed {
        pk_phase_e           phase;
        logic [ADDR_W-1:0]   waddr;
        logic [LANE_W-1:0]   lane;
        logic [CNT_W-1:0]    left;
        logic [WORD_W-1:0]   old_w;
        logic [WORD_W-1:0]   new_w;
        pk_status_e          result;
        logic                done;
    } pk_ctx_t;

    pk_ctx_t ctx_d, ctx_q;

    logic [WORD_W-1:0] merged_w;
    logic              erased_ok;

    bwp_lane_merge #(
        .N_LANES (LANES)
    ) u_merge (
        .word_in  (ctx_q.new_w),
        .lane_sel (ctx_q.lane),
        .byte_in  (byte_data),
        .word_out (merged_w)
    );

    bwp_erase_check #(
        .W (WORD_W)
    ) u_erase (
        .stored (ctx_q.old_w),
        .wanted (ctx_q.new_w),
        .ok     (erased_ok)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.phase)
            PH_IDLE: begin
                if (start) begin
                    ctx_d.waddr = {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    ctx_d.lane  = start_addr[LANE_W-1:0];
                    ctx_d.left  = byte_count;
                    if (byte_count == '0) begin
                        ctx_d.done   = 1'b1;
                        ctx_d.result = ST_OK;
                    end else begin
                        ctx_d.phase = PH_READ;
                    end
                end
            end
            PH_READ: begin
                // Stored word seeds both the merge base and the erase reference
                if (rd_valid) begin
                    ctx_d.old_w = rd_data;
                    ctx_d.new_w = rd_data;
                    ctx_d.phase = PH_FILL;
                end
            end
            PH_FILL: begin
                if (byte_valid) begin
                    ctx_d.new_w = merged_w;
                    ctx_d.left  = ctx_q.left - ONE_LEFT;
                    ctx_d.lane  = ctx_q.lane + 1'b1;
                    if (ctx_q.lane == LAST_LANE || ctx_q.left == ONE_LEFT) begin
                        ctx_d.phase = PH_CHECK;
                    end
                end
            end
            PH_CHECK: begin
                if (erased_ok) begin
                    ctx_d.phase = PH_PROG;
                end else begin
                    ctx_d.phase  = PH_IDLE;
                    ctx_d.done   = 1'b1;
                    ctx_d.result = ST_NOT_ERASED;
                end
            end
            PH_PROG: begin
                if (prog_ack) begin
                    if (prog_status != 2'd0) begin
                        ctx_d.phase  = PH_IDLE;
                        ctx_d.done   = 1'b1;
                        ctx_d.result = pk_status_e'(prog_status);
                    end else if (ctx_q.left == '0) begin
                        ctx_d.phase  = PH_IDLE;
                        ctx_d.done   = 1'b1;
                        ctx_d.result = ST_OK;
                    end else begin
                        ctx_d.waddr = ctx_q.waddr + WORD_STEP;
                        ctx_d.lane  = '0;
                        ctx_d.phase = PH_READ;
                    end
                end
            end
            default: begin
                ctx_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign byte_ready = (ctx_q.phase == PH_FILL);
    assign rd_req     = (ctx_q.phase == PH_READ);
    assign prog_req   = (ctx_q.phase == PH_PROG);
    assign rd_addr    = ctx_q.waddr;
    assign prog_addr  = ctx_q.waddr;
    assign prog_data  = ctx_q.new_w;
    assign busy       = (ctx_q.phase != PH_IDLE);
    assign done       = ctx_q.done;
    assign status     = ctx_q.result;

endmodule

// File: rtl/bwp_packer_chk.sv
module bwp_packer_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_ready,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [31:0]       prog_data,
    input logic              prog_ack,
    input logic              busy,
    input logic              done
);

    logic [31:0]       last_rd;
    logic              rd_seen;
    logic [ADDR_W-1:0] prev_pa;
    logic              have_prev;
    logic              prog_was;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_rd   <= '0;
            rd_seen   <= 1'b0;
            prev_pa   <= '0;
            have_prev <= 1'b0;
            prog_was  <= 1'b0;
        end else begin
            prog_was <= prog_req;
            if (rd_req && rd_valid) begin
                last_rd <= rd_data;
                rd_seen <= 1'b1;
            end
            if (prog_req && prog_ack) begin
                rd_seen   <= 1'b0;
                prev_pa   <= prog_addr;
                have_prev <= 1'b1;
            end
            if (!busy) begin
                have_prev <= 1'b0;
            end
        end
    end

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || prog_req) |-> (rd_addr[1:0] == 2'b00 && prog_addr[1:0] == 2'b00)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_was && have_prev) |-> (prog_addr == prev_pa + ADDR_W'(4))); // R1

    AST_ERASED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ((last_rd & prog_data) == prog_data)); // R5

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && prog_req)); // R8

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> rd_seen); // R8

    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_ack) |=> (prog_req && $stable(prog_addr) && $stable(prog_data))); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> busy); // R10

endmodule

bind bwp_packer bwp_packer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_ready (byte_ready),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .prog_ack   (prog_ack),
    .busy       (busy),
    .done       (done)
);

// File: tb/bwp_packer_tb.sv
`timescale 1ns/1ps
module bwp_packer_tb;

    localparam int AW    = 6;
    localparam int CW    = 6;
    localparam int WORDS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          byte_ready;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          prog_req;
    logic [AW-1:0] prog_addr;
    logic [31:0]   prog_data;
    logic          prog_ack = 1'b0;
    logic [1:0]    prog_status = '0;
    logic          busy;
    logic          done;
    logic [1:0]    status;

    always #2.5 clk = ~clk;

    bwp_packer #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .prog_req(prog_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .prog_ack(prog_ack),
        .prog_status(prog_status), .busy(busy), .done(done), .status(status)
    );

    // Flash array and controller model
    logic [31:0] mem  [WORDS];
    logic [31:0] snap [WORDS];
    int          n_prog = 0;
    int          n_rd = 0;
    int          fail_at = -1;
    logic [1:0]  fail_code = 2'd0;
    logic [AW-1:0] first_pa = '0;
    logic [AW-1:0] last_pa = '0;

    always @(posedge clk) begin
        rd_valid <= rd_req && !rd_valid;
        rd_data  <= mem[rd_addr[AW-1:2]];
        if (rd_req && !rd_valid) n_rd <= n_rd + 1;
        prog_ack <= prog_req && !prog_ack;
        if (prog_req && !prog_ack) begin
            n_prog <= n_prog + 1;
            if (n_prog == 0) first_pa <= prog_addr;
            last_pa <= prog_addr;
            if (n_prog == fail_at) begin
                prog_status <= fail_code;
            end else begin
                prog_status <= 2'd0;
                mem[prog_addr[AW-1:2]] <= prog_data;
            end
        end
    end

    int         done_cnt = 0;
    logic [1:0] last_status = '0;
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt    = done_cnt + 1;
            last_status = status;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int k, input int seed);
        return 8'((k * 29 + seed * 7) | 1);
    endfunction

    function automatic logic [7:0] mbyte(input int a);
        return mem[a / 4][8 * (a % 4) +: 8];
    endfunction

    function automatic logic [7:0] sbyte(input int a);
        return snap[a / 4][8 * (a % 4) +: 8];
    endfunction

    task automatic set_byte(input int a, input logic [7:0] v);
        mem[a / 4][8 * (a % 4) +: 8] = v;
    endtask

    // Arbitrary neighbour contents, erased bytes under the transfer
    task automatic preload(input int s, input int c);
        for (int w = 0; w < WORDS; w++)
            mem[w] = 32'h5A3C_9612 ^ (w * 32'h0107_0B0D);
        for (int a = s; a < s + c; a++)
            set_byte(a, 8'hFF);
    endtask

    task automatic take_snap();
        for (int w = 0; w < WORDS; w++) snap[w] = mem[w];
    endtask

    int run_base = 0;

    task automatic run_xfer(input int s, input int c, input int seed, input int f_at,
                            input logic [1:0] f_code, input bit glitch, output int consumed);
        int its;
        int k;
        run_base  = done_cnt;
        n_prog    = 0;
        n_rd      = 0;
        fail_at   = f_at;
        fail_code = f_code;
        @(negedge clk);
        start      = 1'b1;
        start_addr = AW'(s);
        byte_count = CW'(c);
        @(negedge clk);
        start = 1'b0;
        k   = 0;
        its = 0;
        forever begin
            @(negedge clk);
            #1;
            if (done_cnt != run_base) break;
            its++;
            if (its > 3000) begin
                chk("watchdog: transfer hung", its, 0);
                break;
            end
            if (glitch && its == 3) begin
                start      = 1'b1;
                start_addr = AW'(1);
                byte_count = CW'(5);
            end else begin
                start = 1'b0;
            end
            byte_valid = (k < c);
            byte_data  = dat(k, seed);
            if (byte_valid && byte_ready) k++;
        end
        start      = 1'b0;
        byte_valid = 1'b0;
        consumed   = k;
    endtask

    task automatic check_ok(input int s, input int c, input int seed, input int consumed);
        int nw;
        int e1, e2, e3, e4;
        int ws, we;
        nw = (c == 0) ? 0 : ((s % 4) + c + 3) / 4;
        chk("R9 single done pulse", done_cnt - run_base, 1);
        chk("R9 success status", last_status, 0);
        chk("R1 words programmed", n_prog, nw);
        chk("R8 one read per word", n_rd, nw);
        chk("R10 bytes accepted", consumed, c);
        if (nw > 0) begin
            chk("R1 first word address", first_pa, s & ~3);
            chk("R1 last word address", last_pa, (s & ~3) + 4 * (nw - 1));
        end else begin
            chk("R7 zero count issues nothing", n_prog + n_rd, 0);
        end
        e1 = 0; e2 = 0; e3 = 0; e4 = 0;
        ws = s / 4;
        we = (s + c - 1) / 4;
        for (int a = 0; a < 4 * WORDS; a++) begin
            if (a >= s && a < s + c) begin
                if (mbyte(a) != dat(a - s, seed)) e2++;
            end else if (c > 0 && a / 4 == ws && a < s) begin
                if (mbyte(a) != sbyte(a)) e3++;
            end else if (c > 0 && a / 4 == we && a >= s + c) begin
                if (mbyte(a) != sbyte(a)) e4++;
            end else begin
                if (mbyte(a) != sbyte(a)) e1++;
            end
        end
        chk("R2 transfer bytes in little-endian lanes", e2, 0);
        chk("R3 head lanes keep stored bytes", e3, 0);
        chk("R4 tail lanes keep stored bytes", e4, 0);
        chk("R1 words outside transfer untouched", e1, 0);
    endtask

    // Global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got;
        for (int w = 0; w < WORDS; w++) mem[w] = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 byte_ready low after reset", byte_ready, 0);
        chk("R9 busy low after reset", busy, 0);
        chk("R9 done low after reset", done, 0);
        chk("R9 status zero after reset", status, 0);
        chk("R8 no requests after reset", {rd_req, prog_req}, 0);

        // R5: zero byte under the first word
        preload(12, 6);
        set_byte(13, 8'h00);
        take_snap();
        run_xfer(12, 6, 3, -1, 2'd0, 1'b0, got);
        chk("R5 not-erased status", last_status, 1);
        chk("R5 no program request", n_prog, 0);
        chk("R5 bytes taken before stop", got, 4);
        chk("R5 word left unchanged", mem[3], snap[3]);
        chk("R9 done pulse on failure", done_cnt - run_base, 1);

        // R5: zero byte under the second word
        preload(14, 8);
        set_byte(17, 8'h00);
        take_snap();
        run_xfer(14, 8, 4, -1, 2'd0, 1'b0, got);
        chk("R5 not-erased status later word", last_status, 1);
        chk("R5 words programmed before stop", n_prog, 1);
        chk("R5 bytes taken before stop later word", got, 6);
        chk("R5 failing word unchanged", mem[4], snap[4]);

        // R6: timeout on first program
        preload(20, 10);
        take_snap();
        run_xfer(20, 10, 5, 0, 2'd2, 1'b0, got);
        chk("R6 timeout status", last_status, 2);
        chk("R6 single program request", n_prog, 1);
        chk("R6 single read", n_rd, 1);
        chk("R6 bytes taken before timeout", got, 4);

        // R6: protection error on second program
        preload(21, 10);
        take_snap();
        run_xfer(21, 10, 6, 1, 2'd3, 1'b0, got);
        chk("R6 protection status", last_status, 3);
        chk("R6 requests before protection stop", n_prog, 2);
        chk("R6 reads before protection stop", n_rd, 2);
        chk("R6 bytes taken before protection stop", got, 7);
        chk("R6 idle ready after stop", byte_ready, 0);

        // Sweep offsets and counts at two bases
        for (int b = 0; b < 2; b++) begin
            for (int off = 0; off < 4; off++) begin
                for (int c = 0; c < 14; c++) begin
                    int s;
                    s = (b == 0 ? 8 : 40) + off;
                    preload(s, c);
                    take_snap();
                    run_xfer(s, c, b * 64 + off * 16 + c, -1, 2'd0, 1'b0, got);
                    check_ok(s, c, b * 64 + off * 16 + c, got);
                end
            end
        end

        // R10: start pulse during a running transfer is ignored
        preload(26, 9);
        take_snap();
        run_xfer(26, 9, 9, -1, 2'd0, 1'b1, got);
        check_ok(26, 9, 9, got);
        chk("R10 mid-transfer start ignored", first_pa, 24);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule